// File: doc/BRIEF.md
# Configurable Serial Register-Write Receiver

This block is a receive-only serial slave. A host drives an active-low select, a serial clock and a data line, and the block turns each frame into one or more register write strobes on the system clock. Each frame opens with an address field. One or more 8-bit data bytes follow it, and each byte lands at its own register address, so a single frame can fill several consecutive registers. The block has no return data line and never drives anything back to the host.

The block holds a small format register of its own at address 0x1. Through it the host picks a 4-bit or an 8-bit address field, the bit order of every field, and whether burst addresses count down or up. It can also request a soft reset. Each format bit is accepted only when its mirror copy in the upper nibble is written as well. This stops a corrupted byte from silently switching the framing. All three serial pins are brought into the system clock domain through synchronizers, so the system clock must run at least four times faster than the serial clock.

The write port is a valid-only stream with no back-pressure. A strobe lasts one cycle, and the register file that consumes it must take it in that cycle. Two strobes are always at least eight serial clocks apart.

Top module: `spi_regwr_rx`

## Requirements
- R1: After reset a frame is a 4-bit address followed by 8-bit data bytes, each field sent most significant bit first. With one byte this is a 12-bit frame.
- R2: A bit is taken only on a rising serial-clock edge while select is low. A rising edge of select ends the frame and gives one `frame_end` pulse.
- R3: Each data byte after the first goes to the previous byte's address minus one by default. The address wraps within the active address width (0x0 steps to 0xF in 4-bit mode, and to 0xFF in 8-bit mode).
- R4: A write to address 0x1 loads the format register. Bits 0..3 are soft reset, LSB-first, ascending and wide address. Their mirror copies sit at bits 7, 6, 5 and 4 in that order. A function is enabled only when the bit and its mirror are both 1.
- R5: When ascending is enabled, burst bytes go to the previous address plus one, with the same wrap rule as R3.
- R6: When wide address is enabled, the address field is 8 bits. The format in force (width, bit order, direction) is captured when select falls, so a format write changes only the frames that start after it.
- R7: When LSB-first is enabled, the first bit of the address field and the first bit of each data byte are that field's least significant bit.
- R8: A write to 0x1 with bits 0 and 7 both set pulses `soft_rst` in the same cycle as its write strobe and returns the format register to its reset state. The other bits of that byte are ignored.
- R9: A completed byte whose address is above 0x3 produces no write strobe. The burst address still advances past it.
- R10: Bits left over at the end of a frame that do not complete a data byte are discarded and produce no write.
- R11: `wr_valid` (with `soft_rst`) rises exactly three system-clock edges after the serial-clock rising edge of a byte's last bit. `frame_end` rises exactly three edges after select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, data taken on its rising edge |
| spi_sdata | input | 1 | Serial data from the host |
| wr_valid | output | 1 | One-cycle write strobe, no back-pressure |
| wr_addr | output | 8 | Register address of the write (upper bits zero in 4-bit mode) |
| wr_data | output | 8 | Data byte of the write |
| frame_end | output | 1 | One-cycle pulse when a frame closes |
| soft_rst | output | 1 | One-cycle soft-reset request |

## Verification
Every result is due a fixed number of cycles after its cause. Each write strobe and soft-reset pulse comes three system-clock edges after the serial-clock rise that carries the byte's last bit. Each frame-end pulse comes three edges after select rises. The bench drives its pins on falling system-clock edges and notes the edge count at the moment it raises the serial clock or the select. It samples the outputs on falling edges and checks that every strobe and every frame-end pulse appears exactly three edges later. At the end of each frame it also compares the collected writes, soft-reset pulses and frame-end count against a bench model of the format register.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  // Frame format held by the format register and captured per frame.
  typedef struct packed {
    logic addr_wide;   // 8-bit address field instead of 4-bit
    logic ascending;   // burst addresses count up
    logic lsb_first;   // fields arrive least significant bit first
  } spi_fmt_t;

  localparam spi_fmt_t FMT_RESET = '0;

  // Positions of the enable bits inside the decoded (mirror-checked) nibble.
  localparam int EFF_SOFT = 0;
  localparam int EFF_LSB  = 1;
  localparam int EFF_ASC  = 2;
  localparam int EFF_WIDE = 3;

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser
  import spi_rx_pkg::*;
#(
  parameter int ADDR_W_MIN = 4,
  parameter int ADDR_W_MAX = 8,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  frame_stop,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  input  spi_fmt_t              fmt_in,
  output logic                  byte_vld,
  output logic [ADDR_W_MAX-1:0] byte_addr,
  output logic [DATA_W-1:0]     byte_data
);

  localparam int FLD_W = (ADDR_W_MAX > DATA_W) ? ADDR_W_MAX : DATA_W;
  localparam int CNT_W = $clog2(FLD_W);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(ADDR_W_MIN - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(ADDR_W_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_DATA   = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W_MAX-1:0] MASK_NARROW = ADDR_W_MAX'((1 << ADDR_W_MIN) - 1);
  localparam logic [ADDR_W_MAX-1:0] ONE_ADDR    = ADDR_W_MAX'(1);

  spi_fmt_t              fmt_q;
  logic                  active;
  logic                  in_data;
  logic [CNT_W-1:0]      cnt;
  logic [FLD_W-1:0]      fld;
  logic [ADDR_W_MAX-1:0] cur_addr;

  logic [CNT_W-1:0]      last_idx;
  logic [CNT_W-1:0]      pos;
  logic [FLD_W-1:0]      fld_nxt;
  logic                  field_done;
  logic [ADDR_W_MAX-1:0] amask;
  logic [ADDR_W_MAX-1:0] addr_step;

  always_comb begin
    if (in_data)              last_idx = LAST_DATA;
    else if (fmt_q.addr_wide) last_idx = LAST_WIDE;
    else                      last_idx = LAST_NARROW;
    pos          = fmt_q.lsb_first ? cnt : (last_idx - cnt);
    fld_nxt      = fld;
    fld_nxt[pos] = bit_val;
    field_done   = (cnt == last_idx);
    amask        = fmt_q.addr_wide ? '1 : MASK_NARROW;
    addr_step    = (fmt_q.ascending ? (cur_addr + ONE_ADDR) : (cur_addr - ONE_ADDR)) & amask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q     <= FMT_RESET;
      active    <= 1'b0;
      in_data   <= 1'b0;
      cnt       <= '0;
      fld       <= '0;
      cur_addr  <= '0;
      byte_vld  <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (frame_start) begin
        fmt_q   <= fmt_in;
        active  <= 1'b1;
        in_data <= 1'b0;
        cnt     <= '0;
        fld     <= '0;
      end else if (frame_stop) begin
        active <= 1'b0;
        cnt    <= '0;
        fld    <= '0;
      end else if (bit_stb && active) begin
        if (field_done) begin
          cnt <= '0;
          fld <= '0;
          if (!in_data) begin
            cur_addr <= fld_nxt[ADDR_W_MAX-1:0];
            in_data  <= 1'b1;
          end else begin
            byte_vld  <= 1'b1;
            byte_addr <= cur_addr;
            byte_data <= fld_nxt[DATA_W-1:0];
            cur_addr  <= addr_step;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
          fld <= fld_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/spi_rx_mode.sv
module spi_rx_mode
  import spi_rx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output spi_fmt_t          fmt,
  output logic              soft_rst
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] eff;
  logic              hit;

  for (genvar i = 0; i < HALF_W; i++) begin : g_mirror
    assign eff[i] = wr_data[i] & wr_data[DATA_W-1-i];
  end

  assign hit      = wr_fire && (wr_addr == ADDR_W'(MODE_ADDR));
  assign soft_rst = hit && eff[EFF_SOFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt <= FMT_RESET;
    end else if (soft_rst) begin
      fmt <= FMT_RESET;
    end else if (hit) begin
      fmt.addr_wide <= eff[EFF_WIDE];
      fmt.ascending <= eff[EFF_ASC];
      fmt.lsb_first <= eff[EFF_LSB];
    end
  end

endmodule

// File: rtl/spi_regwr_rx.sv
module spi_regwr_rx
  import spi_rx_pkg::*;
#(
  parameter int ADDR_W_MIN  = 4,
  parameter int ADDR_W_MAX  = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_ADDR   = 1,
  parameter int LAST_ADDR   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_cs_n,
  input  logic                  spi_sclk,
  input  logic                  spi_sdata,
  output logic                  wr_valid,
  output logic [ADDR_W_MAX-1:0] wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  frame_end,
  output logic                  soft_rst
);

  logic [2:0] pins_s;
  logic       cs_s, sclk_s, sdata_s;
  logic       cs_d, sclk_d;
  logic       bit_stb, frame_start, frame_stop;
  logic       byte_vld;
  logic [ADDR_W_MAX-1:0] byte_addr;
  logic [DATA_W-1:0]     byte_data;
  spi_fmt_t   fmt;

  spi_rx_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_sdata}),
    .q     (pins_s)
  );

  assign {cs_s, sclk_s, sdata_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      cs_d      <= cs_s;
      sclk_d    <= sclk_s;
      frame_end <= frame_stop;
    end
  end

  assign bit_stb     = sclk_s & ~sclk_d & ~cs_s;
  assign frame_start = ~cs_s & cs_d;
  assign frame_stop  = cs_s & ~cs_d;

  spi_rx_deser #(
    .ADDR_W_MIN (ADDR_W_MIN),
    .ADDR_W_MAX (ADDR_W_MAX),
    .DATA_W     (DATA_W)
  ) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_stop  (frame_stop),
    .bit_stb     (bit_stb),
    .bit_val     (sdata_s),
    .fmt_in      (fmt),
    .byte_vld    (byte_vld),
    .byte_addr   (byte_addr),
    .byte_data   (byte_data)
  );

  assign wr_valid = byte_vld && (byte_addr <= ADDR_W_MAX'(LAST_ADDR));
  assign wr_addr  = byte_addr;
  assign wr_data  = byte_data;

  spi_rx_mode #(
    .ADDR_W    (ADDR_W_MAX),
    .DATA_W    (DATA_W),
    .MODE_ADDR (MODE_ADDR)
  ) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_valid),
    .wr_addr  (byte_addr),
    .wr_data  (byte_data),
    .fmt      (fmt),
    .soft_rst (soft_rst)
  );

endmodule

// File: rtl/spi_regwr_rx_chk.sv
module spi_regwr_rx_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 1,
  parameter int LAST_ADDR = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              frame_end,
  input logic              soft_rst
);

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr <= ADDR_W'(LAST_ADDR))); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R3

  AST_SOFT_FROM_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (wr_valid && wr_addr == ADDR_W'(MODE_ADDR) && wr_data[0] && wr_data[DATA_W-1])); // R8

  AST_END_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !wr_valid); // R2

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end); // R2

endmodule

bind spi_regwr_rx spi_regwr_rx_chk #(
  .ADDR_W    (ADDR_W_MAX),
  .DATA_W    (DATA_W),
  .MODE_ADDR (MODE_ADDR),
  .LAST_ADDR (LAST_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .frame_end (frame_end),
  .soft_rst  (soft_rst)
);

// File: tb/test_spi_regwr_rx.sv
module test_spi_regwr_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       wr_valid, frame_end, soft_rst;
  logic [7:0] wr_addr, wr_data;

  always #2 clk = ~clk;  // 250 MHz

  spi_regwr_rx i_spi_regwr_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (cs_n),
    .spi_sclk  (sclk),
    .spi_sdata (sdata),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_end (frame_end),
    .soft_rst  (soft_rst)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int rise_cyc = 0;
  int cs_cyc = 0;
  bit done = 0;

  // bench model of the format register
  bit m_wide = 0, m_lsb = 0, m_asc = 0;

  logic [7:0] tx_bytes[$];
  logic [7:0] obs_a[$], obs_d[$], exp_a[$], exp_d[$];
  int obs_soft, obs_end, exp_soft;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        obs_a.push_back(wr_addr);
        obs_d.push_back(wr_data);
        check(cyc - rise_cyc == 3, "R11 write latency", cyc - rise_cyc, 3);
      end
      if (soft_rst) obs_soft++;
      if (frame_end) begin
        obs_end++;
        check(cyc - cs_cyc == 3, "R11 frame end latency", cyc - cs_cyc, 3);
      end
    end
  end

  task automatic apply_mode(input logic [7:0] d);
    if (d[0] & d[7]) begin
      m_wide = 0; m_lsb = 0; m_asc = 0;
      exp_soft++;
    end else begin
      m_lsb  = d[1] & d[6];
      m_asc  = d[2] & d[5];
      m_wide = d[3] & d[4];
    end
  endtask

  task automatic run_frame(input int addr, input int extra, input string req);
    bit lsb = m_lsb;
    bit asc = m_asc;
    int fw = m_wide ? 8 : 4;
    int mask = m_wide ? 255 : 15;
    bit bits[$];
    int a;
    for (int i = 0; i < fw; i++) bits.push_back(addr[lsb ? i : fw - 1 - i]);
    foreach (tx_bytes[j])
      for (int i = 0; i < 8; i++) bits.push_back(tx_bytes[j][lsb ? i : 7 - i]);
    for (int i = 0; i < extra; i++) bits.push_back(1'($urandom_range(0, 1)));
    // expected writes
    exp_a.delete(); exp_d.delete(); exp_soft = 0;
    a = addr & mask;
    foreach (tx_bytes[j]) begin
      if (a <= 3) begin
        exp_a.push_back(8'(a));
        exp_d.push_back(tx_bytes[j]);
        if (a == 1) apply_mode(tx_bytes[j]);
      end
      a = (asc ? a + 1 : a - 1) & mask;
    end
    obs_a.delete(); obs_d.delete(); obs_soft = 0; obs_end = 0;
    // drive
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    foreach (bits[k]) begin
      sdata = bits[k];
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      rise_cyc = cyc;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    cs_cyc = cyc;
    repeat (8) @(negedge clk);
    // compare
    check(obs_a.size() == exp_a.size(), {req, " write count"}, obs_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < obs_a.size(); i++) begin
      check(obs_a[i] == exp_a[i], {req, " write address"}, obs_a[i], exp_a[i]);
      check(obs_d[i] == exp_d[i], {req, " write data"}, obs_d[i], exp_d[i]);
    end
    check(obs_soft == exp_soft, {req, " R8 soft reset pulses"}, obs_soft, exp_soft);
    check(obs_end == 1, {req, " R2 frame end count"}, obs_end, 1);
    tx_bytes.delete();
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!wr_valid && !frame_end && !soft_rst, "R2 reset state", {wr_valid, frame_end, soft_rst}, 0);

    tx_bytes = '{8'hA5};             run_frame(0, 0, "R1 default frame");
    tx_bytes = '{8'h3C, 8'h77, 8'h00}; run_frame(3, 0, "R3 descending burst");
    tx_bytes = '{8'h11};             run_frame(9, 0, "R9 high address ignored");
    tx_bytes = '{8'h21, 8'h22, 8'h5A}; run_frame(5, 0, "R9 burst into range");
    tx_bytes = '{8'h90, 8'h91};      run_frame(0, 0, "R3 descending wrap");
    tx_bytes = '{8'hC3};             run_frame(0, 5, "R10 leftover bits");
    tx_bytes = '{8'h04};             run_frame(1, 0, "R4 bit without mirror");
    tx_bytes = '{8'h12, 8'h34};      run_frame(2, 0, "R4 still descending");
    tx_bytes = '{8'h24};             run_frame(1, 0, "R5 enable ascending");
    tx_bytes = '{8'h41, 8'h42, 8'h43}; run_frame(2, 0, "R5 ascending burst");
    tx_bytes = '{8'h66};             run_frame(1, 0, "R7 enable lsb first");
    tx_bytes = '{8'h1E, 8'h87};      run_frame(2, 0, "R7 lsb first burst");
    tx_bytes = '{8'h7E};             run_frame(1, 0, "R6 enable wide address");
    tx_bytes = '{8'hB4, 8'h4B};      run_frame(8'h02, 0, "R6 wide address frame");
    tx_bytes = '{8'hEE};             run_frame(8'h80, 0, "R6 R9 wide high address");
    tx_bytes = '{8'hFF, 8'h55};      run_frame(8'hFF, 0, "R6 R5 wide wrap");
    tx_bytes = '{8'h81};             run_frame(1, 0, "R8 soft reset");
    tx_bytes = '{8'h6D};             run_frame(0, 0, "R8 R1 default after soft reset");

    for (int n = 0; n < 150; n++) begin
      int nb = $urandom_range(1, 3);
      int ad = m_wide ? (($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 5))
                      : $urandom_range(0, 6);
      int ex = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      for (int b = 0; b < nb; b++) begin
        logic [7:0] d = 8'($urandom);
        if ($urandom_range(0, 9) != 0) d[7] = 1'b0;
        tx_bytes.push_back(d);
      end
      run_frame(ad, ex, "R3 R5 R6 R7 random frame");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule